// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Unit

This block watches a bank of already-sampled input pins and turns selected transitions or levels on each pin into a sticky per-pin status bit. Three per-bit type masks choose the trigger condition for each pin. An enable mask decides which status bits reach the single combined interrupt line that goes to a parent interrupt controller. Software services an interrupt by reading the status word and writing ones to the bits it has handled.

Software reaches the five registers through a small single-cycle write/read port. A register is selected by its byte offset. The read data is combinational on the offset. A write lands on the next rising clock edge.

Top module: `pin_irq_trigger`

## Requirements
- R1: Offsets 0x00 (enable), 0x04 (type0), 0x08 (type1) and 0x0C (type2) read back the last value written to them. Any other offset except 0x10 reads zero, and a write to such an offset changes no register.
- R2: After a synchronous active-low reset, all five registers read zero and `irq_o` is low.
- R3: When type2=0, type1=0 and type0=0 for a pin, a 1-to-0 change of that pin between two consecutive clocks sets its status bit on the second clock.
- R4: When type2=0, type1=0 and type0=1 for a pin, a 0-to-1 change sets its status bit. A 1-to-0 change does not set it.
- R5: When type2=0 and type1=1 for a pin, the pin sets its status bit on every clock where it equals type0. So type0=1 gives an active-high level and type0=0 gives an active-low level.
- R6: When type2=1 for a pin, both rising and falling changes set its status bit, whatever type1 and type0 hold. A steady level never sets it.
- R7: Writing the status offset (0x10) clears exactly the status bits written as one and leaves the others unchanged. When a clear and a set hit the same bit on the same clock, the clear wins. A pin still at its active level therefore sets the bit again on the following clock.
- R8: `irq_o` equals, one clock later, the OR over all pins of status AND enable. With the enable register at zero, `irq_o` stays low even when status bits are set.
- R9: The first clock after reset only captures the pins as the reference for edge detection. A pin held steady through and after reset reports no edge.
- R10: A status bit, once set, stays set until it is cleared through the status offset, even if the pin returns to its idle value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | WIDTH | Sampled pin values, one bit per pin |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | ADDR_W | Byte offset of the selected register |
| reg_wdata_i | input | WIDTH | Write data |
| reg_rdata_o | output | WIDTH | Read data of the selected register (combinational) |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The pins are driven with single-bit falls and rises, opposite-direction changes on neighbouring bits, and steady high and low levels. This separates edge from level detection and rising from falling edges. Each mode is also given the transition it must ignore.

Dual-edge mode is run with type1 and type0 also set, to show that type2 takes priority. Clears are issued while a level stays active, to expose which side wins a same-cycle conflict. Enable is switched while status is set, which shows the one-cycle delay and the masking on `irq_o`.

A behavioural per-bit model in the bench is compared with `irq_o` and the read data on every clock.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  // Byte offsets of the register port (the software view depends on them)
  localparam int OFS_ENABLE = 'h00;
  localparam int OFS_TYPE0  = 'h04;
  localparam int OFS_TYPE1  = 'h08;
  localparam int OFS_TYPE2  = 'h0C;
  localparam int OFS_STATUS = 'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_TYPE0,
    SEL_TYPE1,
    SEL_TYPE2,
    SEL_STATUS
  } reg_sel_e;

  function automatic reg_sel_e offset_to_sel(input int ofs);
    case (ofs)
      OFS_ENABLE: return SEL_ENABLE;
      OFS_TYPE0:  return SEL_TYPE0;
      OFS_TYPE1:  return SEL_TYPE1;
      OFS_TYPE2:  return SEL_TYPE2;
      OFS_STATUS: return SEL_STATUS;
      default:    return SEL_NONE;
    endcase
  endfunction

  // Trigger decision for one pin. Priority: dual edge, then level, then single edge.
  function automatic logic trig_hit(input logic t0, input logic t1, input logic t2,
                                    input logic pin, input logic prev, input logic armed);
    if (t2) return armed & (pin ^ prev);
    if (t1) return ~(pin ^ t0);
    if (t0) return armed & pin & ~prev;
    return armed & ~pin & prev;
  endfunction

endpackage

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  status_i,
  output logic [WIDTH-1:0]  enable_o,
  output logic [WIDTH-1:0]  type0_o,
  output logic [WIDTH-1:0]  type1_o,
  output logic [WIDTH-1:0]  type2_o,
  output logic [WIDTH-1:0]  clr_o,
  output logic [WIDTH-1:0]  rdata_o
);

  reg_sel_e sel;
  assign sel = offset_to_sel(int'(addr_i));

  logic [WIDTH-1:0] enable_q, type0_q, type1_q, type2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      type0_q  <= '0;
      type1_q  <= '0;
      type2_q  <= '0;
    end else if (wr_i) begin
      case (sel)
        SEL_ENABLE: enable_q <= wdata_i;
        SEL_TYPE0:  type0_q  <= wdata_i;
        SEL_TYPE1:  type1_q  <= wdata_i;
        SEL_TYPE2:  type2_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  // Write-one-to-clear vector for the status register
  assign clr_o = (wr_i && sel == SEL_STATUS) ? wdata_i : '0;

  always_comb begin
    case (sel)
      SEL_ENABLE: rdata_o = enable_q;
      SEL_TYPE0:  rdata_o = type0_q;
      SEL_TYPE1:  rdata_o = type1_q;
      SEL_TYPE2:  rdata_o = type2_q;
      SEL_STATUS: rdata_o = status_i;
      default:    rdata_o = '0;
    endcase
  end

  assign enable_o = enable_q;
  assign type0_o  = type0_q;
  assign type1_o  = type1_q;
  assign type2_o  = type2_q;

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel == SEL_NONE) |=> $stable(enable_q) && $stable(type0_q)
                                  && $stable(type1_q) && $stable(type2_q)); // R1

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] type0_i,
  input  logic [WIDTH-1:0] type1_i,
  input  logic [WIDTH-1:0] type2_i,
  output logic [WIDTH-1:0] set_o
);

  logic [WIDTH-1:0] prev_q;
  logic             armed_q;

  // The first clock after reset only captures the reference value
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= pin_i;
      armed_q <= 1'b1;
    end
  end

  logic [WIDTH-1:0] changed;
  assign changed = armed_q ? (pin_i ^ prev_q) : '0;

  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    assign set_o[b] = trig_hit(type0_i[b], type1_i[b], type2_i[b],
                               pin_i[b], prev_q[b], armed_q);
  end

  // Without a change and outside level mode nothing may be reported
  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_o & ~changed & (type2_i | ~type1_i)) == '0)); // R9

endmodule

// File: rtl/pin_irq_status.sv
module pin_irq_status #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);

  logic [WIDTH-1:0] status_q;

  // Clear takes precedence over a set landing on the same clock
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q | set_i) & ~clr_i;
  end

  assign status_o = status_q;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((status_q & $past(clr_i)) == '0)); // R7

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i))); // R10

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & ~clr_i) != '0) |=> ((status_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i))); // R3

endmodule

// File: rtl/pin_irq_combine.sv
module pin_irq_combine #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] status_i,
  input  logic [WIDTH-1:0] enable_i,
  output logic             irq_o
);

  logic [WIDTH-1:0] pending;
  logic             irq_q;

  assign pending = status_i & enable_i;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pending;
  end

  assign irq_o = irq_q;

  AST_MASKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i == '0) |=> !irq_q); // R8

  AST_STATUS_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i == '0) |=> !irq_q); // R8

endmodule

// File: rtl/pin_irq_trigger.sv
module pin_irq_trigger #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  pin_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WIDTH-1:0]  reg_wdata_i,
  output logic [WIDTH-1:0]  reg_rdata_o,
  output logic              irq_o
);

  logic [WIDTH-1:0] enable_w, type0_w, type1_w, type2_w;
  logic [WIDTH-1:0] clr_w, set_w, status_w;

  pin_irq_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status_w),
    .enable_o (enable_w),
    .type0_o  (type0_w),
    .type1_o  (type1_w),
    .type2_o  (type2_w),
    .clr_o    (clr_w),
    .rdata_o  (reg_rdata_o)
  );

  pin_irq_detect #(.WIDTH(WIDTH)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_i),
    .type0_i (type0_w),
    .type1_i (type1_w),
    .type2_i (type2_w),
    .set_o   (set_w)
  );

  pin_irq_status #(.WIDTH(WIDTH)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_w),
    .clr_i    (clr_w),
    .status_o (status_w)
  );

  pin_irq_combine #(.WIDTH(WIDTH)) u_combine (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_w),
    .enable_i (enable_w),
    .irq_o    (irq_o)
  );

  // Level mode with the pin at its active level and no clear sets the bit
  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((type1_w & ~type2_w & ~(pin_i ^ type0_w) & ~clr_w) != '0)
      |=> ((status_w & $past(type1_w & ~type2_w & ~(pin_i ^ type0_w) & ~clr_w))
           == $past(type1_w & ~type2_w & ~(pin_i ^ type0_w) & ~clr_w))); // R5

endmodule

// File: tb/pin_irq_trigger_bench.sv
module pin_irq_trigger_bench;

  localparam int W = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  pin_i = '0;
  logic          reg_wr_i = 1'b0;
  logic [AW-1:0] reg_addr_i = '0;
  logic [W-1:0]  reg_wdata_i = '0;
  logic [W-1:0]  reg_rdata_o;
  logic          irq_o;

  int total = 0;
  int bad = 0;
  string phase = "R2";

  always #4 clk = ~clk;  // 125 MHz

  pin_irq_trigger #(.WIDTH(W), .ADDR_W(AW)) u_pin_irq_trigger (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o));

  // ---------------- behavioural reference ----------------
  bit [W-1:0] m_en, m_t0, m_t1, m_t2, m_st, m_prev;
  bit m_armed, m_irq;

  always @(posedge clk) begin
    bit [W-1:0] nst;
    if (!rst_n) begin
      m_en = 0; m_t0 = 0; m_t1 = 0; m_t2 = 0; m_st = 0; m_prev = 0;
      m_armed = 0; m_irq = 0;
    end else begin
      m_irq = (m_st & m_en) != 0;
      nst = m_st;
      for (int b = 0; b < W; b++) begin
        bit p, q, hit;
        p = pin_i[b]; q = m_prev[b];
        if (m_t2[b])      hit = m_armed && (p != q);
        else if (m_t1[b]) hit = (p == m_t0[b]);
        else if (m_t0[b]) hit = m_armed && p && !q;
        else              hit = m_armed && !p && q;
        if (hit) nst[b] = 1'b1;
        if (reg_wr_i && reg_addr_i == 5'h10 && reg_wdata_i[b]) nst[b] = 1'b0;
      end
      m_st = nst;
      if (reg_wr_i) begin
        if (reg_addr_i == 5'h00) m_en = reg_wdata_i;
        if (reg_addr_i == 5'h04) m_t0 = reg_wdata_i;
        if (reg_addr_i == 5'h08) m_t1 = reg_wdata_i;
        if (reg_addr_i == 5'h0C) m_t2 = reg_wdata_i;
      end
      m_prev = pin_i;
      m_armed = 1;
    end
  end

  function automatic bit [W-1:0] m_read(input bit [AW-1:0] a);
    case (a)
      5'h00: return m_en;
      5'h04: return m_t0;
      5'h08: return m_t1;
      5'h0C: return m_t2;
      5'h10: return m_st;
      default: return '0;
    endcase
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (irq_o !== m_irq || reg_rdata_o !== m_read(reg_addr_i)) begin
        bad++;
        $display("FAIL %s per-cycle: irq=%0b rdata=%h expected irq=%0b rdata=%h",
                 phase, irq_o, reg_rdata_o, m_irq, m_read(reg_addr_i));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(posedge clk); #1;
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(posedge clk); #1;
    reg_addr_i = a;
    @(negedge clk);
    d = reg_rdata_o;
  endtask

  task automatic set_pins(input logic [W-1:0] v);
    @(posedge clk); #1;
    pin_i = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  bit finished = 0;

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    pin_i = 32'hFFFF_0000;
    idle(3);
    #1 rst_n = 1'b1;
    // R2 reset state
    phase = "R2";
    check("R2 irq after reset", {31'b0, irq_o}, '0);
    for (int k = 0; k < 5; k++) begin
      rd(AW'(k * 4), v);
      check("R2 register reads zero", v, '0);
    end
    // R9 steady pins after reset: no edge in falling mode
    phase = "R9";
    idle(3);
    rd(5'h10, v);
    check("R9 no spurious edge", v, '0);
    // R1 register map
    phase = "R1";
    wr(5'h00, 32'h0000_0000);
    wr(5'h04, 32'hA5A5_0F0F);
    wr(5'h08, 32'h1234_5678);
    wr(5'h0C, 32'h0000_0000);
    rd(5'h04, v); check("R1 type0 readback", v, 32'hA5A5_0F0F);
    rd(5'h08, v); check("R1 type1 readback", v, 32'h1234_5678);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h06, 32'hFFFF_FFFF);
    rd(5'h14, v); check("R1 unmapped read", v, '0);
    rd(5'h0C, v); check("R1 unmapped write ignored type2", v, '0);
    rd(5'h00, v); check("R1 unmapped write ignored enable", v, '0);
    // back to plain falling-edge mode, all status cleared
    wr(5'h04, '0); wr(5'h08, '0);
    wr(5'h10, 32'hFFFF_FFFF);
    // R3 falling edge
    phase = "R3";
    set_pins(32'h0000_0018);
    idle(2);
    wr(5'h10, 32'hFFFF_FFFF);
    set_pins(32'h0000_0010);        // bit3 falls
    idle(2);
    rd(5'h10, v); check("R3 falling edge sets bit3", v, 32'h0000_0008);
    // R10 stays set after pin goes back high
    phase = "R10";
    set_pins(32'h0000_0018);
    idle(3);
    rd(5'h10, v); check("R10 status sticky", v, 32'h0000_0008);
    // R4 rising edge on bit4 mode; bit4 falls -> nothing, then rises
    phase = "R4";
    wr(5'h04, 32'h0000_0010);
    wr(5'h10, 32'hFFFF_FFFF);
    set_pins(32'h0000_0008);        // bit4 falls (rising mode) bit3 steady
    idle(2);
    rd(5'h10, v); check("R4 fall ignored in rising mode", v, '0);
    set_pins(32'h0000_0018);        // bit4 rises
    idle(2);
    rd(5'h10, v); check("R4 rising edge sets bit4", v, 32'h0000_0010);
    // R7 single-bit clear
    phase = "R7";
    set_pins(32'h0000_0010);        // bit3 falls (falling mode)
    idle(2);
    rd(5'h10, v); check("R7 two bits pending", v, 32'h0000_0018);
    wr(5'h10, 32'h0000_0008);
    rd(5'h10, v); check("R7 clear one bit only", v, 32'h0000_0010);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, v); check("R7 clear all", v, '0);
    // R5 level modes: bit0 active-high, bit1 active-low
    phase = "R5";
    wr(5'h04, 32'h0000_0001);
    wr(5'h08, 32'h0000_0003);
    set_pins(32'h0000_0003);        // bit0 high (active), bit1 high (inactive)
    wr(5'h10, 32'hFFFF_FFFF);
    idle(2);
    rd(5'h10, v); check("R5 level high sets, level low idle", v, 32'h0000_0001);
    set_pins(32'h0000_0000);        // bit0 inactive, bit1 active
    wr(5'h10, 32'h0000_0001);
    idle(1);
    rd(5'h10, v); check("R5 active-low level sets", v, 32'h0000_0002);
    // R7 clear wins, level re-sets next clock
    phase = "R7";
    @(posedge clk); #1;
    reg_addr_i = 5'h10; reg_wdata_i = 32'h0000_0002; reg_wr_i = 1'b1;
    @(posedge clk); #1;
    reg_wr_i = 1'b0;
    @(negedge clk);
    check("R7 clear wins same clock", reg_rdata_o, '0);
    @(negedge clk);
    check("R7 level re-sets next clock", reg_rdata_o, 32'h0000_0002);
    // R6 dual edge overrides level and polarity on bit0
    phase = "R6";
    wr(5'h08, 32'h0000_0001);
    wr(5'h04, 32'h0000_0001);
    wr(5'h0C, 32'h0000_0001);
    set_pins(32'h0000_0001);        // bit0 rises
    idle(1);
    wr(5'h10, 32'hFFFF_FFFF);
    idle(3);
    rd(5'h10, v); check("R6 steady high does not set", v, '0);
    set_pins(32'h0000_0000);        // bit0 falls
    idle(2);
    rd(5'h10, v); check("R6 falling edge sets", v, 32'h0000_0001);
    wr(5'h10, 32'h0000_0001);
    set_pins(32'h0000_0001);        // bit0 rises
    idle(2);
    rd(5'h10, v); check("R6 rising edge sets", v, 32'h0000_0001);
    // R8 enable gating and one-clock delay
    phase = "R8";
    idle(2);
    check("R8 masked irq low", {31'b0, irq_o}, '0);
    wr(5'h00, 32'h0000_0001);       // enable lands at this edge
    @(negedge clk);
    check("R8 irq one clock after enable", {31'b0, irq_o}, '0);
    @(negedge clk);
    check("R8 irq high when enabled", {31'b0, irq_o}, 32'h1);
    wr(5'h00, 32'h0000_0000);
    idle(1);
    check("R8 irq low when all masked", {31'b0, irq_o}, '0);
    rd(5'h10, v); check("R8 status kept while masked", v, 32'h0000_0001);
    idle(4);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule